// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words over a three-line serial port: a serial clock, a serial data line and a load strobe. All three lines are asynchronous to the system clock. They pass through synchronizers, and the block samples them in the system clock domain. Each rising edge of the serial clock moves one data bit into a 32-bit shift register. The first bit sent is the most significant bit of the word.

A rising load strobe commits the word in the shift register. The three low bits of that word are an address. They pick one of five 32-bit control latches. The whole word, address bits included, is copied into the chosen latch. The block also raises a single-cycle update pulse for that latch, so the logic downstream knows when to decode the new contents. Addresses that name no latch are dropped. Serial clock edges that arrive while the strobe is high do not touch the shift register.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted, and after reset until the first transfer, every latch reads zero and every update pulse is low.
- R2: Each synchronized rising edge of the serial clock shifts the data bit into bit 0 of the shift register and moves the older bits up by one. The first bit sent ends up at bit 31. Only the last 32 bits sent before a transfer count.
- R3: On a transfer, word bits [2:0] form the address. Values 0, 1, 2, 3 and 4 load the whole 32-bit word into latch 0, 1, 2, 3 and 4.
- R4: On a transfer whose word bits [2:0] are 5, 6 or 7, no latch changes and no update pulse is raised.
- R5: A transfer raises the addressed latch's update pulse for exactly one system clock cycle. In that same cycle the latch shows its new contents. A latch never changes without its pulse, and at most one pulse is high at a time.
- R6: While the load strobe is high, serial clock edges and serial data are ignored. Strobing again without any new shifting transfers the same word once more.
- R7: Holding the load strobe high for many cycles causes only one transfer. The next transfer needs the strobe to go low and then rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Load strobe; its rising edge commits the word |
| latch_q_o | output | 160 | Latch contents; latch k occupies bits [32k+31:32k] |
| latch_upd_o | output | 5 | One-cycle update pulse, one bit per latch |

## Verification
The hardest case to reach from the ports is serial clock activity during a high load strobe. A correct design shows no effect at that moment, so the effect has to be made visible later. The bench toggles the serial clock several times with conflicting data while the strobe is high, lowers the strobe, and then strobes again with no shifting in between. The second transfer must deliver the original word to the same latch, which proves the shift register was untouched. Random words carrying every address value, including the ignored ones, are mixed with an over-length word and a long strobe. These expose extra pulses, stretched pulses and writes to the wrong latch.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int unsigned CFG_WORD_W    = 32;
   localparam int unsigned CFG_ADDR_W    = 3;
   localparam int unsigned CFG_NUM_LATCH = 5;
   localparam int unsigned CFG_SYNC_DEPTH = 2;
endpackage

// File: rtl/cfg_sync_bus.sv
module cfg_sync_bus #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("cfg_sync_bus: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cfg_sync_bus: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;

   // R7: a rise strobe never lasts two cycles
   a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              hold_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W < 2) begin : g_bad_width
      $error("cfg_shift_reg: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sh_q;
   logic              advance;

   assign advance = step_i & ~hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (advance) sh_q <= {sh_q[WORD_W-2:0], bit_i};
   end

   assign word_o = sh_q;

   // R6: contents frozen while the load strobe is high
   a_r6_frozen_under_load: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(word_o));
   // R2: a step lands the sampled bit at the bottom and moves older bits up
   a_r2_bit_enters_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !hold_i) |=> (word_o[0] == $past(bit_i)) &&
                             (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned NUM_LATCH = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        xfer_i,
   input  logic [WORD_W-1:0]           word_i,
   output logic [NUM_LATCH*WORD_W-1:0] q_o,
   output logic [NUM_LATCH-1:0]        upd_o
);
   localparam int unsigned SLOTS = 1 << ADDR_W;

   if (NUM_LATCH > SLOTS) begin : g_bad_count
      $error("cfg_latch_bank: NUM_LATCH exceeds the address space");
   end
   if (ADDR_W >= WORD_W) begin : g_bad_addr
      $error("cfg_latch_bank: ADDR_W must be narrower than WORD_W");
   end

   logic [ADDR_W-1:0] addr;
   logic              addr_valid;

   assign addr       = word_i[ADDR_W-1:0];
   assign addr_valid = ({1'b0, addr} < (ADDR_W+1)'(NUM_LATCH));

   for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
      logic [WORD_W-1:0] val_q;
      logic              upd_q;
      logic              hit;

      assign hit = xfer_i & (addr == ADDR_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            upd_q <= 1'b0;
         end else begin
            upd_q <= hit;
            if (hit) val_q <= word_i;
         end
      end

      assign q_o[k*WORD_W +: WORD_W] = val_q;
      assign upd_o[k]                = upd_q;

      // R5: a pulse lasts one cycle because a transfer strobe lasts one cycle
      a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         upd_o[k] |=> !upd_o[k]);
      // R5: contents change only together with the pulse
      a_r5_change_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(q_o[k*WORD_W +: WORD_W]) |-> upd_o[k]);
      // R3: an addressed transfer delivers the word
      a_r3_word_delivered: assert property (@(posedge clk) disable iff (!rst_n)
         (xfer_i && addr == ADDR_W'(k)) |=>
            (upd_o[k] && q_o[k*WORD_W +: WORD_W] == $past(word_i)));
   end

   // R5: never more than one pulse at once
   a_r5_onehot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_o));
   // R4: out-of-range addresses raise no pulse
   a_r4_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !addr_valid) |=> (upd_o == '0));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int unsigned WORD_W     = CFG_WORD_W,
   parameter int unsigned ADDR_W     = CFG_ADDR_W,
   parameter int unsigned NUM_LATCH  = CFG_NUM_LATCH,
   parameter int unsigned SYNC_DEPTH = CFG_SYNC_DEPTH
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ser_clk_i,
   input  logic                        ser_data_i,
   input  logic                        ser_load_i,
   output logic [NUM_LATCH*WORD_W-1:0] latch_q_o,
   output logic [NUM_LATCH-1:0]        latch_upd_o
);
   localparam int unsigned LINES = 3;

   if (NUM_LATCH < 1) begin : g_bad_latches
      $error("serial_cfg_loader: NUM_LATCH must be at least 1");
   end

   logic [LINES-1:0] lines_sync;
   logic             sclk_lvl, sdata_lvl, load_lvl;
   logic             sclk_rise, load_rise;
   logic [WORD_W-1:0] shift_word;

   cfg_sync_bus #(.WIDTH(LINES), .STAGES(SYNC_DEPTH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_load_i, ser_clk_i, ser_data_i}),
      .sync_o  (lines_sync)
   );

   assign sdata_lvl = lines_sync[0];
   assign sclk_lvl  = lines_sync[1];
   assign load_lvl  = lines_sync[2];

   cfg_rise_det u_sclk_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (sclk_lvl),
      .rise_o  (sclk_rise)
   );

   cfg_rise_det u_load_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (load_lvl),
      .rise_o  (load_rise)
   );

   cfg_shift_reg #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (sclk_rise),
      .hold_i (load_lvl),
      .bit_i  (sdata_lvl),
      .word_o (shift_word)
   );

   cfg_latch_bank #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .NUM_LATCH (NUM_LATCH)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer_i (load_rise),
      .word_i (shift_word),
      .q_o    (latch_q_o),
      .upd_o  (latch_upd_o)
   );

   // R7: a strobe that stays high yields no second transfer
   a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (load_lvl && $past(load_lvl)) |-> !load_rise);
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
   localparam int W = 32;
   localparam int N = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [N*W-1:0] latch_q;
   logic [N-1:0]   latch_upd;

   int vectors = 0;
   int fails   = 0;
   int pulse_cnt [N];
   int exp_cnt   [N];
   logic [W-1:0] exp_q [N];
   logic [W-1:0] exp_sh = '0;

   always #10 clk = ~clk;

   serial_cfg_loader dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk_i   (ser_clk),
      .ser_data_i  (ser_data),
      .ser_load_i  (ser_load),
      .latch_q_o   (latch_q),
      .latch_upd_o (latch_upd)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < N; i++) if (latch_upd[i]) pulse_cnt[i]++;
      end
   end

   function automatic logic [W-1:0] model_shift(logic [W-1:0] cur, logic b);
      return {cur[W-2:0], b};
   endfunction

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      ser_data = b;
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(1);
      exp_sh = model_shift(exp_sh, b);
   endtask

   task automatic send_word(logic [W-1:0] w);
      for (int b = W-1; b >= 0; b--) send_bit(w[b]);
   endtask

   task automatic commit(int hold);
      int a;
      ser_load = 1'b1;
      wait_clk(hold);
      ser_load = 1'b0;
      wait_clk(8);
      a = int'(exp_sh[2:0]);
      if (a < N) begin
         exp_q[a] = exp_sh;
         exp_cnt[a]++;
      end
   endtask

   task automatic check_all(string req);
      vectors++;
      for (int i = 0; i < N; i++) begin
         if (latch_q[i*W +: W] !== exp_q[i] || pulse_cnt[i] != exp_cnt[i]) begin
            fails++;
            $display("FAIL %s latch %0d: value %h pulses %0d, expected value %h pulses %0d",
                     req, i, latch_q[i*W +: W], pulse_cnt[i], exp_q[i], exp_cnt[i]);
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : stim
      logic [W-1:0] w;
      void'($urandom(32'd4711));
      for (int i = 0; i < N; i++) begin
         pulse_cnt[i] = 0; exp_cnt[i] = 0; exp_q[i] = '0;
      end
      wait_clk(5);
      // R1: state during reset
      vectors++;
      if (latch_q !== '0 || latch_upd !== '0) begin
         fails++;
         $display("FAIL R1 in reset: q %h upd %b, expected zero", latch_q, latch_upd);
      end
      rst_n = 1'b1;
      wait_clk(5);
      check_all("R1");

      // R3: every valid address in turn
      for (int a = 0; a < N; a++) begin
         send_word({28'hA5C3_0F1, 1'b0, 3'(a)} ^ {29'(a * 32'h0101_0101), 3'b000});
         commit(4);
         check_all("R3");
      end

      // R4: the ignored address values
      for (int a = 5; a < 8; a++) begin
         send_word({29'h1BAD_CAFE, 3'(a)});
         commit(4);
         check_all("R4");
      end

      // R2: over-length word, only the last 32 bits count
      for (int b = 0; b < 8; b++) send_bit(1'(b));
      send_word(32'h1234_5672);
      commit(4);
      check_all("R2");

      // R6: serial activity under a high strobe is ignored
      send_word(32'hCAFE_0003);
      ser_load = 1'b1;
      wait_clk(6);
      begin
         logic [W-1:0] saved;
         saved = exp_sh;
         for (int t = 0; t < 5; t++) begin
            ser_data = ~ser_data;
            wait_clk(3); ser_clk = 1'b1; wait_clk(3); ser_clk = 1'b0; wait_clk(2);
         end
         ser_load = 1'b0;
         wait_clk(8);
         exp_q[3] = saved; exp_cnt[3]++;
         check_all("R6");
         // R6: strobe again with no shifting, same word expected again
         exp_q[3] = 32'h0;
         commit(4);
         if (exp_q[3] != saved) $display("FAIL R6 bench model mismatch, expected %h", saved);
         check_all("R6");
      end

      // R7: long strobe gives one pulse
      send_word(32'h0F0F_F001);
      commit(60);
      check_all("R7");

      // R5: random words, pulse counts and isolation of other latches
      for (int k = 0; k < 40; k++) begin
         w = $urandom;
         send_word(w);
         commit(2 + int'($urandom_range(0, 6)));
         check_all("R5");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule